// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block performs exception entry and exception return for a processor that runs at four privilege levels, numbered 0 (least privileged) through 3 (most privileged). An exception request arrives as a set of per-kind request bits (synchronous, IRQ, FIQ, system error) together with the interrupted context: its privilege level, its stack-pointer choice, whether it was executing in 32-bit state, its interrupt mask bits and the address to resume at. In one clock edge the block picks the winning kind, settles the destination level, derives the handler address from that level's vector table, records the resume address and the interrupted context in storage owned by the destination level, and issues a one-cycle redirect to instruction fetch.

A return request names the level being left. The block restores the context saved for that level and redirects fetch to that level's stored resume address. Levels 1 to 3 each own a vector base, a resume-address register and a saved-context register. Level 0 owns none and is never a destination.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `redir_valid` is 0, `cur_level` is 3, `cur_mask` is 4'hF, `cur_sp_sel` is 1 and `cur_aa32` is 0.
- R2: The destination level is the larger of `req_target` and `req_cur_level`, and a result of 0 becomes 1. A request never lowers the level.
- R3: When several bits of `req_valid` are set, the highest index wins. Bit 3 is system error (kind code 3), bit 2 is FIQ (2), bit 1 is IRQ (1) and bit 0 is synchronous (0).
- R4: The handler address is the destination level's base OR origin*0x200 OR kind*0x80. The origin code is 0 for the same level using the level-0 stack pointer (`req_sp_sel`=0), 1 for the same level with its own stack pointer, 2 for a lower level in 64-bit state and 3 for a lower level in 32-bit state (`req_aa32`=1).
- R5: The low 11 bits of a written vector base are ignored, so a table is always 2 KB aligned.
- R6: On entry, only the destination level's resume-address register is written. When `req_aa32`=1 the stored value is `req_ret_addr[31:0]` zero-extended. The other levels' registers keep their contents.
- R7: An entry request sampled at a clock edge makes `redir_valid` high for one cycle after that edge, with the handler address. In the same cycle `cur_level` equals the destination, `cur_mask`=4'hF, `cur_sp_sel`=1 and `cur_aa32`=0.
- R8: On entry, the interrupted level, stack-pointer choice, width and mask bits are saved for the destination level. A return from that level (`eret_valid`, `eret_level`) restores them to the `cur_*` outputs and redirects to the stored resume address one cycle later.
- R9: A return naming level 0 is ignored: there is no redirect and the `cur_*` outputs keep their values. An entry and a return in the same cycle perform only the entry.
- R10: A base write with `base_sel`=0 changes no vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Per-kind exception requests (bit index = kind code) |
| req_target | input | 2 | Requested destination level |
| req_cur_level | input | 2 | Level of the interrupted context |
| req_sp_sel | input | 1 | Interrupted context uses its own stack pointer |
| req_aa32 | input | 1 | Interrupted context was in 32-bit state |
| req_mask | input | 4 | Interrupt mask bits of the interrupted context |
| req_ret_addr | input | 64 | Preferred resume address |
| eret_valid | input | 1 | Return request |
| eret_level | input | 2 | Level being returned from |
| base_we | input | 1 | Vector base write enable |
| base_sel | input | 2 | Level whose vector base is written |
| base_wdata | input | 64 | Vector base write data |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_addr | output | 64 | Redirect target address |
| cur_level | output | 2 | Current privilege level |
| cur_sp_sel | output | 1 | Current stack-pointer choice |
| cur_aa32 | output | 1 | Current 32-bit state flag |
| cur_mask | output | 4 | Current interrupt mask bits |

## Verification
The hardest case to reach is a return that must find one level's resume address and saved context intact after a second entry has written another level. That sequence cannot be seen in a single request. The stimulus first enters level 2 with one context, then enters level 1 from a 32-bit context with a resume address whose upper half is non-zero, and then returns from each level in turn. Each redirect and each restored context shows whether the wrong level was written and whether the zero-extension took place. Collisions are reached directly: entry and return in the same cycle, a return naming level 0, and a base write aimed at level 0.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int N_LVL  = 4;
  localparam int LVL_W  = 2;
  localparam int N_KIND = 4;
  localparam int KIND_W = 2;
  localparam int MASK_W = 4;
  localparam int SLOT_SHIFT  = 7;   // 0x80-byte slots
  localparam int ALIGN_BITS  = 11;  // 2 KB table

  typedef enum logic [KIND_W-1:0] {
    KIND_SYNC = 2'd0,
    KIND_IRQ  = 2'd1,
    KIND_FIQ  = 2'd2,
    KIND_SERR = 2'd3
  } exc_kind_e;

  typedef enum logic [1:0] {
    ORG_SAME_SP0 = 2'd0,
    ORG_SAME_SPX = 2'd1,
    ORG_LOW_64   = 2'd2,
    ORG_LOW_32   = 2'd3
  } exc_origin_e;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic              sp_sel;
    logic              aa32;
    logic [MASK_W-1:0] mask;
  } exc_ctx_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [N_KIND-1:0] req,
  output logic              any,
  output exc_kind_e         kind
);
  // Highest index wins: system error over FIQ over IRQ over synchronous.
  always_comb begin
    kind = KIND_SYNC;
    for (int k = 0; k < N_KIND; k++) begin
      if (req[k]) kind = exc_kind_e'(k[KIND_W-1:0]);
    end
    any = |req;
  end
endmodule

// File: rtl/exc_route.sv
module exc_route
  import exc_pkg::*;
(
  input  logic [LVL_W-1:0] want_lvl,
  input  logic [LVL_W-1:0] from_lvl,
  input  logic             from_sp_sel,
  input  logic             from_aa32,
  output logic [LVL_W-1:0] dest_lvl,
  output exc_origin_e      origin
);
  logic [LVL_W-1:0] raised;

  always_comb begin
    raised   = (want_lvl < from_lvl) ? from_lvl : want_lvl;
    dest_lvl = (raised == '0) ? LVL_W'(1) : raised;
    if (dest_lvl == from_lvl)
      origin = from_sp_sel ? ORG_SAME_SPX : ORG_SAME_SP0;
    else
      origin = from_aa32 ? ORG_LOW_32 : ORG_LOW_64;
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:ALIGN_BITS] base_hi,
  input  exc_origin_e                origin,
  input  exc_kind_e                  kind,
  output logic [ADDR_W-1:0]          handler
);
  localparam int OFS_W = 2 + KIND_W + SLOT_SHIFT;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs     = {origin, kind, {SLOT_SHIFT{1'b0}}};
    handler = {base_hi, {ALIGN_BITS{1'b0}}} | ADDR_W'(ofs);
  end
endmodule

// File: rtl/exc_level_bank.sv
module exc_level_bank
  import exc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       base_we,
  input  logic [LVL_W-1:0]           base_sel,
  input  logic [ADDR_W-1:0]          base_wdata,
  input  logic [LVL_W-1:0]           base_rd_lvl,
  output logic [ADDR_W-1:ALIGN_BITS] base_rd,
  input  logic                       save_en,
  input  logic [LVL_W-1:0]           save_lvl,
  input  logic [ADDR_W-1:0]          save_link,
  input  exc_ctx_t                   save_ctx,
  input  logic [LVL_W-1:0]           ret_rd_lvl,
  output logic [ADDR_W-1:0]          link_rd,
  output exc_ctx_t                   ctx_rd
);
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [HI_W-1:0]   base_q [N_LVL-1:1];
  logic [ADDR_W-1:0] link_q [N_LVL-1:1];
  exc_ctx_t          ctx_q  [N_LVL-1:1];

  for (genvar l = 1; l < N_LVL; l++) begin : g_lvl
    logic [HI_W-1:0]   base_d;
    logic [ADDR_W-1:0] link_d;
    exc_ctx_t          ctx_d;
    logic              base_en, save_hit;

    always_comb begin
      base_en  = base_we && (base_sel == LVL_W'(l));
      save_hit = save_en && (save_lvl == LVL_W'(l));
      base_d   = base_en  ? base_wdata[ADDR_W-1:ALIGN_BITS] : base_q[l];
      link_d   = save_hit ? save_link : link_q[l];
      ctx_d    = save_hit ? save_ctx  : ctx_q[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[l] <= '0;
        link_q[l] <= '0;
        ctx_q[l]  <= '0;
      end else begin
        base_q[l] <= base_d;
        link_q[l] <= link_d;
        ctx_q[l]  <= ctx_d;
      end
    end

    // R6: a level's resume address moves only when that level is the destination
    p_link_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(save_en && save_lvl == LVL_W'(l)) |=> $stable(link_q[l]));
  end

  always_comb begin
    base_rd = '0;
    link_rd = '0;
    ctx_rd  = '0;
    for (int l = 1; l < N_LVL; l++) begin
      if (base_rd_lvl == LVL_W'(l)) base_rd = base_q[l];
      if (ret_rd_lvl == LVL_W'(l)) begin
        link_rd = link_q[l];
        ctx_rd  = ctx_q[l];
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        req_valid,
  input  logic [1:0]        req_target,
  input  logic [1:0]        req_cur_level,
  input  logic              req_sp_sel,
  input  logic              req_aa32,
  input  logic [3:0]        req_mask,
  input  logic [ADDR_W-1:0] req_ret_addr,
  input  logic              eret_valid,
  input  logic [1:0]        eret_level,
  input  logic              base_we,
  input  logic [1:0]        base_sel,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic [1:0]        cur_level,
  output logic              cur_sp_sel,
  output logic              cur_aa32,
  output logic [3:0]        cur_mask
);
  localparam int HALF_W = 32;

  logic                       take;
  exc_kind_e                  kind;
  logic [LVL_W-1:0]           dest_lvl;
  exc_origin_e                origin;
  logic [ADDR_W-1:ALIGN_BITS] dest_base;
  logic [ADDR_W-1:0]          handler;
  logic [ADDR_W-1:0]          link_wr;
  logic [ADDR_W-1:0]          link_rd;
  exc_ctx_t                   ctx_wr, ctx_rd;
  logic                       ret_take;

  exc_arbiter u_arb (
    .req  (req_valid),
    .any  (take),
    .kind (kind)
  );

  exc_route u_route (
    .want_lvl    (req_target),
    .from_lvl    (req_cur_level),
    .from_sp_sel (req_sp_sel),
    .from_aa32   (req_aa32),
    .dest_lvl    (dest_lvl),
    .origin      (origin)
  );

  exc_vector_calc #(.ADDR_W(ADDR_W)) u_vec (
    .base_hi (dest_base),
    .origin  (origin),
    .kind    (kind),
    .handler (handler)
  );

  always_comb begin
    link_wr = req_aa32 ? {{(ADDR_W-HALF_W){1'b0}}, req_ret_addr[HALF_W-1:0]}
                       : req_ret_addr;
    ctx_wr  = '{lvl: req_cur_level, sp_sel: req_sp_sel,
                aa32: req_aa32, mask: req_mask};
  end

  exc_level_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_we     (base_we),
    .base_sel    (base_sel),
    .base_wdata  (base_wdata),
    .base_rd_lvl (dest_lvl),
    .base_rd     (dest_base),
    .save_en     (take),
    .save_lvl    (dest_lvl),
    .save_link   (link_wr),
    .save_ctx    (ctx_wr),
    .ret_rd_lvl  (eret_level),
    .link_rd     (link_rd),
    .ctx_rd      (ctx_rd)
  );

  // Next-state logic for the redirect and the live context
  logic              redir_valid_d;
  logic [ADDR_W-1:0] redir_addr_d;
  exc_ctx_t          cur_d, cur_q;
  logic              redir_en;

  always_comb begin
    ret_take      = eret_valid && (eret_level != '0) && !take;
    redir_en      = take || ret_take;
    redir_valid_d = redir_en;
    redir_addr_d  = redir_addr;
    cur_d         = cur_q;
    if (take) begin
      redir_addr_d = handler;
      cur_d        = '{lvl: dest_lvl, sp_sel: 1'b1, aa32: 1'b0, mask: '1};
    end else if (ret_take) begin
      redir_addr_d = link_rd;
      cur_d        = ctx_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      cur_q       <= '{lvl: LVL_W'(N_LVL-1), sp_sel: 1'b1, aa32: 1'b0, mask: '1};
    end else begin
      redir_valid <= redir_valid_d;
      if (redir_en) begin
        redir_addr <= redir_addr_d;
        cur_q      <= cur_d;
      end
    end
  end

  assign cur_level  = cur_q.lvl;
  assign cur_sp_sel = cur_q.sp_sel;
  assign cur_aa32   = cur_q.aa32;
  assign cur_mask   = cur_q.mask;

  // R2: entry never drops below the interrupted level and never lands on level 0
  p_no_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |=> (cur_level >= $past(req_cur_level)) && (cur_level != 2'd0));

  // R7: entry leaves every mask bit set
  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |=> (cur_mask == 4'hF) && redir_valid);

  // R4: a handler address always starts a 0x80-byte slot
  p_slot_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |=> (redir_addr[SLOT_SHIFT-1:0] == '0));

  // R9: a redirect must have a cause in the previous cycle
  p_redir_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) && !(eret_valid && eret_level != 2'd0) |=> !redir_valid);

  // R9: a return from level 0 leaves the live context alone
  p_eret0_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) && eret_valid && (eret_level == 2'd0)
      |=> $stable(cur_level) && $stable(cur_mask));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req_valid;
  logic [1:0]  req_target, req_cur_level;
  logic        req_sp_sel, req_aa32;
  logic [3:0]  req_mask;
  logic [63:0] req_ret_addr;
  logic        eret_valid;
  logic [1:0]  eret_level;
  logic        base_we;
  logic [1:0]  base_sel;
  logic [63:0] base_wdata;
  logic        redir_valid;
  logic [63:0] redir_addr;
  logic [1:0]  cur_level;
  logic        cur_sp_sel, cur_aa32;
  logic [3:0]  cur_mask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk, .rst_n, .req_valid, .req_target, .req_cur_level, .req_sp_sel,
    .req_aa32, .req_mask, .req_ret_addr, .eret_valid, .eret_level,
    .base_we, .base_sel, .base_wdata, .redir_valid, .redir_addr,
    .cur_level, .cur_sp_sel, .cur_aa32, .cur_mask
  );

  localparam logic [63:0] B1 = 64'h0000_0000_4000_0000;
  localparam logic [63:0] B2 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] B3 = 64'h0000_00FF_FFFF_F800;

  // {req[3:0], target[1:0], cur[1:0], sp, aa32, exp_level[1:0], exp_addr[63:0]}
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {4'b0001, 2'd1, 2'd0, 1'b0, 1'b0, 2'd1, B1 | 64'h400},
    {4'b0010, 2'd1, 2'd0, 1'b0, 1'b1, 2'd1, B1 | 64'h680},
    {4'b0100, 2'd2, 2'd1, 1'b0, 1'b0, 2'd2, B2 | 64'h500},
    {4'b1000, 2'd3, 2'd3, 1'b0, 1'b0, 2'd3, B3 | 64'h180},
    {4'b0001, 2'd3, 2'd3, 1'b1, 1'b0, 2'd3, B3 | 64'h200},
    {4'b0010, 2'd1, 2'd2, 1'b1, 1'b0, 2'd2, B2 | 64'h280},
    {4'b0100, 2'd0, 2'd0, 1'b0, 1'b1, 2'd1, B1 | 64'h700},
    {4'b1111, 2'd2, 2'd2, 1'b0, 1'b0, 2'd2, B2 | 64'h180},
    {4'b0110, 2'd3, 2'd1, 1'b0, 1'b1, 2'd3, B3 | 64'h700},
    {4'b0011, 2'd1, 2'd1, 1'b0, 1'b0, 2'd1, B1 | 64'h080}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = '0; req_target = '0; req_cur_level = '0; req_sp_sel = 1'b0;
    req_aa32 = 1'b0; req_mask = '0; req_ret_addr = '0; eret_valid = 1'b0;
    eret_level = '0; base_we = 1'b0; base_sel = '0; base_wdata = '0;
  endtask

  task automatic write_base(input logic [1:0] sel, input logic [63:0] d);
    base_we = 1'b1; base_sel = sel; base_wdata = d;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // drive at a falling edge; outputs are sampled one clock later, then inputs cleared
  task automatic entry(input logic [3:0] rq, input logic [1:0] tg, input logic [1:0] cl,
                       input logic sp, input logic a32, input logic [3:0] mk,
                       input logic [63:0] ra);
    req_valid = rq; req_target = tg; req_cur_level = cl; req_sp_sel = sp;
    req_aa32 = a32; req_mask = mk; req_ret_addr = ra;
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic do_eret(input logic [1:0] lv);
    eret_valid = 1'b1; eret_level = lv;
    @(negedge clk);
    eret_valid = 1'b0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 redir_valid", 64'(redir_valid), 64'd0);
    chk("R1 cur_level",   64'(cur_level),   64'd3);
    chk("R1 cur_mask",    64'(cur_mask),    64'hF);
    chk("R1 cur_sp_sel",  64'(cur_sp_sel),  64'd1);
    chk("R1 cur_aa32",    64'(cur_aa32),    64'd0);

    // R5: low bits of the written bases are junk and must be dropped
    write_base(2'd1, B1 | 64'h7FF);
    write_base(2'd2, B2 | 64'h005);
    write_base(2'd3, B3 | 64'h3C1);
    // R10: a write aimed at level 0 must not disturb any table
    write_base(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);

    // R2 R3 R4 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      entry(VEC[i][75:72], VEC[i][71:70], VEC[i][69:68], VEC[i][67], VEC[i][66],
            4'h0, 64'h100 + 64'(i));
      chk("R4 handler address", redir_addr, VEC[i][63:0]);
      chk("R2 destination level", 64'(cur_level), 64'(VEC[i][65:64]));
      chk("R7 redirect pulse", 64'(redir_valid), 64'd1);
      chk("R7 masks set", 64'(cur_mask), 64'hF);
      chk("R7 own stack pointer", 64'(cur_sp_sel), 64'd1);
      chk("R7 64-bit state", 64'(cur_aa32), 64'd0);
      @(negedge clk);
      chk("R7 pulse lasts one cycle", 64'(redir_valid), 64'd0);
    end

    // R6 R8: two nested entries, then unwind
    entry(4'b0010, 2'd2, 2'd1, 1'b1, 1'b0, 4'b0101, 64'h1111_2222_3333_4440);
    chk("R4 R8 entry L2", redir_addr, B2 | 64'h480);
    entry(4'b0001, 2'd1, 2'd0, 1'b0, 1'b1, 4'b0010, 64'hDEAD_BEEF_1234_5678);
    chk("R4 R8 entry L1", redir_addr, B1 | 64'h600);
    do_eret(2'd1);
    chk("R6 zero-extended resume", redir_addr, 64'h0000_0000_1234_5678);
    chk("R8 return pulse", 64'(redir_valid), 64'd1);
    chk("R8 restored level", 64'(cur_level), 64'd0);
    chk("R8 restored aa32", 64'(cur_aa32), 64'd1);
    chk("R8 restored sp", 64'(cur_sp_sel), 64'd0);
    chk("R8 restored mask", 64'(cur_mask), 64'h2);
    do_eret(2'd2);
    chk("R6 other level resume kept", redir_addr, 64'h1111_2222_3333_4440);
    chk("R8 restored level L2 ctx", 64'(cur_level), 64'd1);
    chk("R8 restored mask L2 ctx", 64'(cur_mask), 64'h5);
    chk("R8 restored sp L2 ctx", 64'(cur_sp_sel), 64'd1);
    @(negedge clk);

    // R9: return from level 0 is ignored
    do_eret(2'd0);
    chk("R9 no redirect on level-0 return", 64'(redir_valid), 64'd0);
    chk("R9 level kept", 64'(cur_level), 64'd1);
    chk("R9 mask kept", 64'(cur_mask), 64'h5);

    // R9: entry wins over a simultaneous return
    eret_valid = 1'b1; eret_level = 2'd2;
    entry(4'b0001, 2'd3, 2'd3, 1'b1, 1'b0, 4'h0, 64'h40);
    eret_valid = 1'b0;
    chk("R9 entry beats return", redir_addr, B3 | 64'h200);
    chk("R9 entry level", 64'(cur_level), 64'd3);
    chk("R9 entry masks", 64'(cur_mask), 64'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule